// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical page frame number by reading two levels of translation tables held in memory. A request carries the virtual address and whether the access is a write. The walker takes the current directory base from a base-register input when it accepts the request. It then reads a directory entry, uses that entry to find a second-level table, and reads the final entry. It returns the 20-bit frame number and the 12 status bits of that entry, or it reports a fault that names the level at which an entry was not valid.

The address is split 10/10/12. The top ten bits select one of 1024 word-sized directory entries. The next ten bits select one of 1024 word-sized entries in the table that the directory entry points at. The low twelve bits are the byte offset within the 4 KB frame, and the walker does not use them. Each entry keeps the frame or table base in its upper 20 bits and status flags in its lower 12 bits. On a successful walk, the walker marks the final entry as used, and also as modified for a write. When the entry in memory is missing either mark, the walker writes the updated entry back before it responds.

All memory traffic uses one word port. A request is held under a valid/ready handshake, and read data comes back later with its own strobe. The walker serves one translation at a time.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `req_ready` is 1 and `mem_valid` and `rsp_valid` are 0.
- R2: The first memory access of a walk is a read (`mem_we`=0) at the address `dir_base + 4*vaddr[31:22]`. `dir_base` is sampled in the cycle the request is accepted.
- R3: The second access is a read at `{dir_entry[31:12], 12'h000} + 4*vaddr[21:12]`. The low 12 bits of the directory entry never affect this address.
- R4: If bit 0 (valid) of the directory entry is 0, the walker responds with `rsp_fault`=1 and `rsp_fault_level`=0. `rsp_flags` holds the directory entry's low 12 bits. No further memory access is made for that request.
- R5: If bit 0 of the table entry is 0, the walker responds with `rsp_fault`=1 and `rsp_fault_level`=1. `rsp_flags` holds that entry's low 12 bits. No write is issued.
- R6: On success, `rsp_fault`=0 and `rsp_frame` equals table entry bits 31:12. `rsp_flags` equals the entry's low 12 bits with bit 5 (accessed) set, and with bit 6 (dirty) also set when the request is a write. All other flag bits are unchanged, for example bit 1 write-enable, bit 2 user and bit 8 global.
- R7: On success, exactly one write (`mem_we`=1) is issued to the table entry address, with data `{frame, updated flags}`, when that updated word differs from the word read. Otherwise no write occurs.
- R8: A memory request, once raised, keeps `mem_valid`, `mem_addr` and `mem_we` steady until `mem_ready` is seen. `req_ready` is 0 from acceptance until the one-cycle `rsp_valid` pulse, and it is 1 in the cycle after that pulse.
- R9: Read data is taken only in a cycle with `mem_rvalid`=1. Any delay on `mem_ready` or `mem_rvalid` changes only the timing of a walk, never its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is for a write access |
| dir_base | input | 32 | Directory base register value |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response is a fault |
| rsp_fault_level | output | 1 | Faulting level: 0 directory, 1 table |
| rsp_frame | output | 20 | Physical frame number |
| rsp_flags | output | 12 | Status bits of the returned entry |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory word address (byte address) |
| mem_wdata | output | 32 | Write-back data |
| mem_rvalid | input | 1 | Read data strobe |
| mem_rdata | input | 32 | Read data |

## Verification
The bench goes after the two fault levels. A walker that checked the wrong entry would keep reading after a dead directory entry, or would write back a table entry that was not valid. It also places directory entries whose low 12 bits are all ones, which exposes a design that adds flag bits into the table address. It uses the top directory slot as well, which catches index overflow. It sends one read and one write against entries whose accessed and dirty bits are already set, where a spurious write-back would show up on the port. Finally, it stalls `mem_ready` and delays `mem_rvalid` while the data bus carries an invalid word, so a design that latched data early would report a false fault.

// File: rtl/pt_walk_pkg.sv
`timescale 1ns/1ps
package pt_walk_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned OFF_W  = 12;
  localparam int unsigned IDX_W  = 10;
  localparam int unsigned ENT_SH = 2;
  localparam int unsigned FRM_W  = ADDR_W - OFF_W;

  // status bit positions inside an entry
  localparam int unsigned PTE_V = 0;
  localparam int unsigned PTE_A = 5;
  localparam int unsigned PTE_D = 6;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_DIR_REQ,
    WS_DIR_WAIT,
    WS_TBL_REQ,
    WS_TBL_WAIT,
    WS_WB_REQ,
    WS_RESP
  } walk_state_e;
endpackage

// File: rtl/pt_walk_addr.sv
`timescale 1ns/1ps
module pt_walk_addr #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned ENT_SH = 2
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] dir_entry,
  output logic [ADDR_W-1:0] dir_addr,
  output logic [ADDR_W-1:0] tbl_addr
);
  localparam int unsigned PAD_W = ADDR_W - IDX_W - ENT_SH;

  logic [IDX_W-1:0]  dir_idx;
  logic [IDX_W-1:0]  tbl_idx;
  logic [ADDR_W-1:0] dir_ofs;
  logic [ADDR_W-1:0] tbl_ofs;
  logic [ADDR_W-1:0] tbl_base;

  assign dir_idx  = vaddr[ADDR_W-1 -: IDX_W];
  assign tbl_idx  = vaddr[OFF_W +: IDX_W];
  assign dir_ofs  = {{PAD_W{1'b0}}, dir_idx, {ENT_SH{1'b0}}};
  assign tbl_ofs  = {{PAD_W{1'b0}}, tbl_idx, {ENT_SH{1'b0}}};
  assign tbl_base = {dir_entry[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  assign dir_addr = base + dir_ofs;
  assign tbl_addr = tbl_base + tbl_ofs;
endmodule

// File: rtl/pt_entry_eval.sv
`timescale 1ns/1ps
module pt_entry_eval
  import pt_walk_pkg::*;
#(
  parameter int unsigned ENT_W = 32
) (
  input  logic [ENT_W-1:0] entry,
  input  logic             is_write,
  output logic             valid,
  output logic [ENT_W-1:0] upd_entry,
  output logic             needs_wb
);
  logic [ENT_W-1:0] set_mask;

  always_comb begin
    set_mask        = '0;
    set_mask[PTE_A] = 1'b1;
    set_mask[PTE_D] = is_write;
  end

  assign valid     = entry[PTE_V];
  assign upd_entry = entry | set_mask;
  assign needs_wb  = valid && (upd_entry != entry);
endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker
  import pt_walk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] dir_base,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic              rsp_fault_level,
  output logic [FRM_W-1:0]  rsp_frame,
  output logic [OFF_W-1:0]  rsp_flags,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [ADDR_W-1:0] mem_rdata
);
  walk_state_e       state_q, state_d;
  logic [ADDR_W-1:0] vaddr_q, base_q, dent_q, tent_q, tent_d;
  logic              wr_q, fault_q, lvl_q;
  logic              load_req, load_dent, load_tent;
  logic              set_fault, set_lvl;
  logic [ADDR_W-1:0] dir_addr, tbl_addr;
  logic              ent_valid, ent_wb;
  logic [ADDR_W-1:0] ent_upd;
  logic [ADDR_W-1:0] rsp_src;

  pt_walk_addr #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENT_SH(ENT_SH)
  ) u_addr (
    .vaddr    (vaddr_q),
    .base     (base_q),
    .dir_entry(dent_q),
    .dir_addr (dir_addr),
    .tbl_addr (tbl_addr)
  );

  pt_entry_eval #(.ENT_W(ADDR_W)) u_eval (
    .entry    (mem_rdata),
    .is_write (wr_q),
    .valid    (ent_valid),
    .upd_entry(ent_upd),
    .needs_wb (ent_wb)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    load_req  = 1'b0;
    load_dent = 1'b0;
    load_tent = 1'b0;
    set_fault = 1'b0;
    set_lvl   = 1'b0;
    tent_d    = ent_valid ? ent_upd : mem_rdata;
    unique case (state_q)
      WS_IDLE: if (req_valid) begin
        load_req = 1'b1;
        state_d  = WS_DIR_REQ;
      end
      WS_DIR_REQ:  if (mem_ready) state_d = WS_DIR_WAIT;
      WS_DIR_WAIT: if (mem_rvalid) begin
        load_dent = 1'b1;
        if (ent_valid) begin
          state_d = WS_TBL_REQ;
        end else begin
          set_fault = 1'b1;
          state_d   = WS_RESP;
        end
      end
      WS_TBL_REQ:  if (mem_ready) state_d = WS_TBL_WAIT;
      WS_TBL_WAIT: if (mem_rvalid) begin
        load_tent = 1'b1;
        if (!ent_valid) begin
          set_fault = 1'b1;
          set_lvl   = 1'b1;
          state_d   = WS_RESP;
        end else if (ent_wb) begin
          state_d = WS_WB_REQ;
        end else begin
          state_d = WS_RESP;
        end
      end
      WS_WB_REQ: if (mem_ready) state_d = WS_RESP;
      WS_RESP:   state_d = WS_IDLE;
      default:   state_d = WS_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
      vaddr_q <= '0;
      base_q  <= '0;
      wr_q    <= 1'b0;
      dent_q  <= '0;
      tent_q  <= '0;
      fault_q <= 1'b0;
      lvl_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load_req) begin
        vaddr_q <= req_vaddr;
        base_q  <= dir_base;
        wr_q    <= req_write;
        fault_q <= 1'b0;
        lvl_q   <= 1'b0;
      end
      if (load_dent) dent_q  <= mem_rdata;
      if (load_tent) tent_q  <= tent_d;
      if (set_fault) fault_q <= 1'b1;
      if (set_lvl)   lvl_q   <= 1'b1;
    end
  end

  // outputs
  assign req_ready = (state_q == WS_IDLE);
  assign mem_valid = (state_q == WS_DIR_REQ) || (state_q == WS_TBL_REQ) ||
                     (state_q == WS_WB_REQ);
  assign mem_we    = (state_q == WS_WB_REQ);
  assign mem_addr  = (state_q == WS_DIR_REQ) ? dir_addr : tbl_addr;
  assign mem_wdata = tent_q;

  assign rsp_src         = (fault_q && !lvl_q) ? dent_q : tent_q;
  assign rsp_valid       = (state_q == WS_RESP);
  assign rsp_fault       = fault_q;
  assign rsp_fault_level = lvl_q;
  assign rsp_frame       = rsp_src[ADDR_W-1:OFF_W];
  assign rsp_flags       = rsp_src[OFF_W-1:0];

  // assertions
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we)); // R8
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready); // R8
  AST_OK_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_flags[PTE_A] && rsp_flags[PTE_V]); // R6
  AST_WRITE_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault && wr_q |-> rsp_flags[PTE_D]); // R6
  AST_FAULT_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> !rsp_flags[PTE_V]); // R4 R5
  AST_WB_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> mem_wdata[PTE_A] && mem_wdata[PTE_V]); // R7
endmodule

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  localparam int NVEC = 6;
  localparam logic [31:0] BASE = 32'h0000_1000;
  // {vaddr, write, dir_entry, tbl_entry, exp_fault, exp_level, exp_wb, exp_flags}
  localparam logic [111:0] VECS [NVEC] = '{
    {32'h0040_2003, 1'b0, 32'h0000_2001, 32'h1234_5001, 1'b0, 1'b0, 1'b1, 12'h021},
    {32'h0040_2003, 1'b1, 32'h0000_2001, 32'h1234_5061, 1'b0, 1'b0, 1'b0, 12'h061},
    {32'hFFC0_1ABC, 1'b0, 32'h0000_3007, 32'hABCD_E127, 1'b0, 1'b0, 1'b0, 12'h127},
    {32'h8000_0000, 1'b1, 32'h0000_2FFF, 32'h00BE_E023, 1'b0, 1'b0, 1'b1, 12'h063},
    {32'h1234_5678, 1'b0, 32'h0000_3000, 32'h5555_5001, 1'b1, 1'b0, 1'b0, 12'h000},
    {32'h00C0_3004, 1'b0, 32'h0000_3001, 32'h7777_7FFE, 1'b1, 1'b1, 1'b0, 12'hFFE}
  };

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_vaddr, dir_base;
  logic        rsp_valid, rsp_fault, rsp_fault_level;
  logic [19:0] rsp_frame;
  logic [11:0] rsp_flags;
  logic        mem_valid, mem_ready, mem_we, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .dir_base(dir_base),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_fault_level(rsp_fault_level),
    .rsp_frame(rsp_frame), .rsp_flags(rsp_flags),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // memory model
  logic [31:0] mem [4096];
  bit          stall_en = 0;
  int          rd_lat   = 0;
  logic [7:0]  lfsr = 8'hA5;
  bit          pend = 0;
  int          pend_cnt = 0;
  logic [31:0] pend_data;
  int          rd_total = 0, wr_total = 0;
  logic [31:0] rd_prev, rd_last, wr_addr_l, wr_data_l;
  bit          hold_bad = 0;
  logic [31:0] prev_addr;
  logic        prev_we, prev_wait;

  always @(posedge clk) begin
    lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready <= stall_en ? lfsr[0] : 1'b1;
    mem_rvalid <= 1'b0;
    mem_rdata  <= 32'h0;
    prev_wait  <= rst_n && mem_valid && !mem_ready;
    prev_addr  <= mem_addr;
    prev_we    <= mem_we;
    if (prev_wait && (!mem_valid || mem_addr != prev_addr || mem_we != prev_we))
      hold_bad <= 1;
    if (pend) begin
      if (pend_cnt == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= pend_data;
        pend       <= 0;
      end else begin
        pend_cnt <= pend_cnt - 1;
      end
    end
    if (rst_n && mem_valid && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr[13:2]] <= mem_wdata;
        wr_total  <= wr_total + 1;
        wr_addr_l <= mem_addr;
        wr_data_l <= mem_wdata;
      end else begin
        pend      <= 1;
        pend_cnt  <= rd_lat;
        pend_data <= mem[mem_addr[13:2]];
        rd_total  <= rd_total + 1;
        rd_prev   <= rd_last;
        rd_last   <= mem_addr;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one walk; results returned, ready observed while busy
  task automatic walk(input logic [31:0] va, input logic wr,
                      output logic f, output logic l, output logic [19:0] fr,
                      output logic [11:0] fl, output bit busy_ready, output bit timeout);
    int n;
    busy_ready = 0;
    timeout = 0;
    @(negedge clk);
    req_vaddr = va; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 300) begin
      if (req_ready) busy_ready = 1;
      @(negedge clk);
      n++;
    end
    if (!rsp_valid) timeout = 1;
    f = rsp_fault; l = rsp_fault_level; fr = rsp_frame; fl = rsp_flags;
    @(negedge clk);
  endtask

  task automatic run_vec(input logic [111:0] v, input string tag);
    logic [31:0] va, dent, tent, daddr, taddr, exp_word;
    logic        wr, ef, el, ewb;
    logic [11:0] efl;
    logic        f, l;
    logic [19:0] fr;
    logic [11:0] fl;
    bit          br, to;
    int          r0, w0, nr;
    va = v[111:80]; wr = v[79]; dent = v[78:47]; tent = v[46:15];
    ef = v[14]; el = v[13]; ewb = v[12]; efl = v[11:0];
    daddr = BASE + {20'h0, va[31:22], 2'b00};
    taddr = {dent[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
    mem[daddr[13:2]] = dent;
    mem[taddr[13:2]] = tent;
    r0 = rd_total; w0 = wr_total;
    walk(va, wr, f, l, fr, fl, br, to);
    check(!to, "R8", {tag, " response arrived"}, 32'(to), 32'h0);
    check(!br, "R8", {tag, " ready low while busy"}, 32'(br), 32'h0);
    nr = ef && !el ? 1 : 2;
    check(rd_total - r0 == nr, ef ? (el ? "R5" : "R4") : "R3",
          {tag, " read count"}, 32'(rd_total - r0), 32'(nr));
    if (nr == 1)
      check(rd_last == daddr, "R2", {tag, " dir addr"}, rd_last, daddr);
    else begin
      check(rd_prev == daddr, "R2", {tag, " dir addr"}, rd_prev, daddr);
      check(rd_last == taddr, "R3", {tag, " table addr"}, rd_last, taddr);
    end
    check(f == ef, ef ? "R4" : "R6", {tag, " fault"}, 32'(f), 32'(ef));
    if (ef) check(l == el, el ? "R5" : "R4", {tag, " level"}, 32'(l), 32'(el));
    check(fl == efl, ef ? (el ? "R5" : "R4") : "R6", {tag, " flags"}, 32'(fl), 32'(efl));
    if (!ef) check(fr == tent[31:12], "R6", {tag, " frame"}, 32'(fr), 32'(tent[31:12]));
    check((wr_total - w0) == int'(ewb), ef ? "R5" : "R7", {tag, " write count"},
          32'(wr_total - w0), 32'(ewb));
    exp_word = ewb ? {tent[31:12], efl} : tent;
    check(mem[taddr[13:2]] == exp_word, "R7", {tag, " table word"}, mem[taddr[13:2]], exp_word);
    if (ewb) check(wr_addr_l == taddr, "R7", {tag, " wb addr"}, wr_addr_l, taddr);
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    req_valid = 0; req_write = 0; req_vaddr = 0; dir_base = BASE;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(req_ready && !mem_valid && !rsp_valid, "R1", "reset outputs",
          {29'h0, req_ready, mem_valid, rsp_valid}, 32'h4);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !mem_valid && !rsp_valid, "R1", "after release",
          {29'h0, req_ready, mem_valid, rsp_valid}, 32'h4);

    for (int k = 0; k < NVEC; k++) run_vec(VECS[k], $sformatf("vec%0d", k));

    // R9: stalled handshake and late read data, same results expected
    stall_en = 1; rd_lat = 3;
    for (int k = 0; k < NVEC; k++) run_vec(VECS[k], $sformatf("stall%0d", k));
    stall_en = 0; rd_lat = 0;
    check(!hold_bad, "R8", "request held while stalled", 32'(hold_bad), 32'h0);

    // R2: base sampled at accept, changing it mid-walk has no effect
    begin
      logic f, l; logic [19:0] fr; logic [11:0] fl; bit br, to;
      mem[(32'h0000_1000 + 32'h4) >> 2] = 32'h0000_2001;
      mem[(32'h0000_2000 + 32'h8) >> 2] = 32'h0CAFE061;
      @(negedge clk);
      req_vaddr = 32'h0040_2003; req_write = 0; req_valid = 1;
      @(negedge clk);
      req_valid = 0; dir_base = 32'h0000_3000;
      while (!rsp_valid) @(negedge clk);
      check(rsp_frame == 20'h0CAFE && !rsp_fault, "R2", "base sampled at accept",
            32'(rsp_frame), 32'h0CAFE);
      @(negedge clk);
      dir_base = BASE;
      walk(32'h0040_2003, 1'b0, f, l, fr, fl, br, to);
      check(fr == 20'h0CAFE, "R6", "back-to-back frame", 32'(fr), 32'h0CAFE);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule